// File: doc/BRIEF.md
# SPI-Mode Memory Card Data Block Engine

This block carries the data phase of a memory-card transaction in SPI mode. It starts once a separate command engine has had a read or write command accepted by the card. It talks to the card through a byte-exchange port. Each exchange sends one byte out and returns the byte shifted in during the same eight clocks. The bit-level shifter lies outside this block. Payload bytes leave through a valid/ready byte stream on reads and enter through one on writes.

A read polls with 0xFF until the card sends a start token. It then streams the payload, drops the two check bytes, and either finishes or hunts for the next block. A write leaves one idle byte, then sends a token, the payload and two filler check bytes. It judges the card's data response and polls out the busy phase. Multi-block reads are ended by a built-in stop command, whose first reply byte is discarded. Multi-block writes are ended by a stop token followed by busy polling. The payload is 512 bytes, or 16 bytes for register reads.

Top module: `sdb_xfer_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, `xfer_req` and `wr_ready` are low; `busy`, `done` and `rd_valid` are low after reset.
- R2: On a read, every exchange sends 0xFF. A received 0xFE starts the payload. Any other byte whose top three bits are not all zero is ignored and polling continues.
- R3: The payload is `SHORT_LEN` (16) bytes when `op_short`=1 and `LONG_LEN` (512) bytes otherwise. Read payload bytes appear on `rd_data` in arrival order, and none is lost or repeated under any `rd_ready` pattern. `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low.
- R4: After a read payload, exactly two more 0xFF exchanges take place and their bytes are discarded. A single-block read then ends with `done` and `status`=0 (ok).
- R5: A byte with its top three bits zero received while hunting ends the transfer with `status`=1. The byte is kept on `err_tok`, and no payload is streamed.
- R6: If `TOKEN_LIMIT` hunt bytes (or stop-reply poll bytes) pass without a token (or a reply), the transfer ends with `status`=2.
- R7: A multi-block read hunts for a fresh block after each one, until `stop_req` has been seen. The stop is honoured at the end of a block. The engine then sends 0x4C,0x00,0x00,0x00,0x00,0x61 and discards the next received byte. It polls for a reply byte with bit 7 clear. A zero reply is followed by polling until 0xFF arrives, then `status`=0. A non-zero reply ends the transfer with `status`=3.
- R8: A write sends one 0xFF idle byte, then token 0xFE (single) or 0xFC (multi, every block). The payload bytes follow in the order they were taken from `wr_data`, then two 0xFF check bytes.
- R9: The exchange right after the check bytes sends 0xFF and returns the data response. Its low five bits equal to 0b00101 mean accepted. Any other value ends the transfer with `status`=3 and no busy polling.
- R10: After an accepted response, 0xFF is sent until 0xFF is received. If `BUSY_LIMIT` busy bytes arrive instead, the transfer ends with `status`=2.
- R11: A multi-block write continues with a new 0xFC block after each busy phase, until `stop_req` has been seen. It then sends 0xFD and one 0xFF byte whose reply is ignored, polls busy as in R10, and ends with `status`=0.
- R12: `busy` is high from the cycle after an accepted `start` until the single-cycle `done` pulse, and a `start` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| op_write | input | 1 | 1 = write, 0 = read |
| op_multi | input | 1 | 1 = multi-block transfer |
| op_short | input | 1 | 1 = 16-byte payload, 0 = 512-byte payload |
| stop_req | input | 1 | Pulse: end a multi-block transfer at the next block boundary |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| status | output | 2 | 0 ok, 1 error token, 2 timeout, 3 rejected |
| err_tok | output | 8 | Last error token received |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte valid |
| rd_ready | input | 1 | Read consumer ready |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte valid |
| wr_ready | output | 1 | Engine takes `wr_data` this cycle when `wr_valid` is high |
| xfer_req | output | 1 | Byte exchange requested; held until acknowledged |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Exchange complete (one cycle) |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_ack` |

## Verification
The bench injects non-token noise bytes ahead of the start token. A design that takes any non-0xFF byte as a token would stream garbage, and one that takes 0x7F as an error would end early. In the multi-block read, a stuff byte that looks like a valid reply follows the stop command. A design that skips the discard ends one exchange early and leaves expected host bytes unused. After the multi-block write's stop token, the ignored byte reads 0xFF. A design that polls busy at once would finish early. Backpressure on both streams, a rejected data response, an error token, and both timeouts each show up as a wrong status, a missing or extra exchange, or a stream mismatch.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [1:0] {
    STS_OK      = 2'd0,
    STS_ERRTOK  = 2'd1,
    STS_TIMEOUT = 2'd2,
    STS_REJECT  = 2'd3
  } sdb_sts_e;

  typedef enum logic [4:0] {
    S_IDLE, S_HUNT, S_RDX, S_RCRC, S_CMD, S_STUFF, S_R1, S_BUSY,
    S_GAP, S_TOK, S_WFETCH, S_WDX, S_WCRC, S_RESP, S_STOPTOK, S_STOPGAP
  } sdb_state_e;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] TOK_SINGLE = 8'hFE;
  localparam logic [7:0] TOK_MULTI  = 8'hFC;
  localparam logic [7:0] TOK_STOP   = 8'hFD;

  // top three bits clear marks a read error token
  function automatic logic is_err_token(input logic [7:0] b);
    return b[7:5] == 3'b000;
  endfunction

  // data response accepted code in the low five bits
  function automatic logic resp_accepted(input logic [7:0] b);
    return b[4:0] == 5'b00101;
  endfunction

  // six-byte stop command frame (index 12, zero argument, fixed check byte)
  function automatic logic [7:0] stop_cmd_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h40 | 8'd12;
      3'd5:    return 8'h61;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sdb_count.sv
module sdb_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/sdb_obuf.sv
module sdb_obuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sdb_xfer_engine.sv
module sdb_xfer_engine
  import sdb_pkg::*;
#(
  parameter int LONG_LEN    = 512,
  parameter int SHORT_LEN   = 16,
  parameter int TOKEN_LIMIT = 1024,
  parameter int BUSY_LIMIT  = 65535
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_write,
  input  logic       op_multi,
  input  logic       op_short,
  input  logic       stop_req,
  output logic       busy,
  output logic       done,
  output logic [1:0] status,
  output logic [7:0] err_tok,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  input  logic [7:0] wr_data,
  input  logic       wr_valid,
  output logic       wr_ready,
  output logic       xfer_req,
  output logic [7:0] xfer_tx,
  input  logic       xfer_ack,
  input  logic [7:0] xfer_rx
);
  localparam int MAX_A = (LONG_LEN > TOKEN_LIMIT) ? LONG_LEN : TOKEN_LIMIT;
  localparam int MAXV  = (MAX_A > BUSY_LIMIT) ? MAX_A : BUSY_LIMIT;
  localparam int CW    = $clog2(MAXV + 1);
  localparam logic [CW-1:0] TOK_LAST  = CW'(TOKEN_LIMIT - 1);
  localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY_LIMIT - 1);

  sdb_state_e state, state_n;
  sdb_sts_e   fin_code, sts_q;
  logic       fin, wr_q, multi_q, short_q, stop_pend, fin_pend;
  logic [7:0] wbyte;
  logic [CW-1:0] cnt, pay_last;
  logic       cnt_clr, cnt_inc, load_ob;

  // named internal events for the checker
  logic ev_token, ev_errtok, ev_resp_ok, ev_resp_bad;

  assign pay_last = short_q ? CW'(SHORT_LEN - 1) : CW'(LONG_LEN - 1);

  always_comb begin
    state_n = state; fin = 1'b0; fin_code = STS_OK;
    xfer_req = 1'b0; xfer_tx = FILL_BYTE; wr_ready = 1'b0; load_ob = 1'b0;
    ev_token = 1'b0; ev_errtok = 1'b0; ev_resp_ok = 1'b0; ev_resp_bad = 1'b0;
    case (state)
      S_IDLE: if (start) state_n = op_write ? S_GAP : S_HUNT;
      S_HUNT: begin
        xfer_req = 1'b1;
        if (xfer_ack) begin
          if (xfer_rx == TOK_SINGLE) begin
            state_n = S_RDX; ev_token = 1'b1;
          end else if (is_err_token(xfer_rx)) begin
            fin = 1'b1; fin_code = STS_ERRTOK; ev_errtok = 1'b1;
          end else if (cnt == TOK_LAST) begin
            fin = 1'b1; fin_code = STS_TIMEOUT;
          end
        end
      end
      S_RDX: begin
        xfer_req = !rd_valid;
        if (xfer_ack) begin
          load_ob = 1'b1;
          if (cnt == pay_last) state_n = S_RCRC;
        end
      end
      S_RCRC: begin
        xfer_req = 1'b1;
        if (xfer_ack && cnt == CW'(1)) begin
          if (!multi_q) fin = 1'b1;
          else state_n = stop_pend ? S_CMD : S_HUNT;
        end
      end
      S_CMD: begin
        xfer_req = 1'b1;
        xfer_tx  = stop_cmd_byte(cnt[2:0]);
        if (xfer_ack && cnt == CW'(5)) state_n = S_STUFF;
      end
      S_STUFF: begin
        xfer_req = 1'b1;
        if (xfer_ack) state_n = S_R1;
      end
      S_R1: begin
        xfer_req = 1'b1;
        if (xfer_ack) begin
          if (!xfer_rx[7]) begin
            if (xfer_rx == 8'h00) state_n = S_BUSY;
            else begin fin = 1'b1; fin_code = STS_REJECT; end
          end else if (cnt == TOK_LAST) begin
            fin = 1'b1; fin_code = STS_TIMEOUT;
          end
        end
      end
      S_BUSY: begin
        xfer_req = 1'b1;
        if (xfer_ack) begin
          if (xfer_rx == FILL_BYTE) begin
            if (fin_pend || !multi_q) fin = 1'b1;
            else state_n = stop_pend ? S_STOPTOK : S_TOK;
          end else if (cnt == BUSY_LAST) begin
            fin = 1'b1; fin_code = STS_TIMEOUT;
          end
        end
      end
      S_GAP: begin
        xfer_req = 1'b1;
        if (xfer_ack) state_n = S_TOK;
      end
      S_TOK: begin
        xfer_req = 1'b1;
        xfer_tx  = multi_q ? TOK_MULTI : TOK_SINGLE;
        if (xfer_ack) state_n = S_WFETCH;
      end
      S_WFETCH: begin
        wr_ready = 1'b1;
        if (wr_valid) state_n = S_WDX;
      end
      S_WDX: begin
        xfer_req = 1'b1;
        xfer_tx  = wbyte;
        if (xfer_ack) state_n = (cnt == pay_last) ? S_WCRC : S_WFETCH;
      end
      S_WCRC: begin
        xfer_req = 1'b1;
        if (xfer_ack && cnt == CW'(1)) state_n = S_RESP;
      end
      S_RESP: begin
        xfer_req = 1'b1;
        if (xfer_ack) begin
          if (resp_accepted(xfer_rx)) begin
            state_n = S_BUSY; ev_resp_ok = 1'b1;
          end else begin
            fin = 1'b1; fin_code = STS_REJECT; ev_resp_bad = 1'b1;
          end
        end
      end
      S_STOPTOK: begin
        xfer_req = 1'b1;
        xfer_tx  = TOK_STOP;
        if (xfer_ack) state_n = S_STOPGAP;
      end
      S_STOPGAP: begin
        xfer_req = 1'b1;
        if (xfer_ack) state_n = S_BUSY;
      end
      default: state_n = S_IDLE;
    endcase
    if (fin) state_n = S_IDLE;
  end

  // one counter serves payload index, frame index and poll count
  assign cnt_clr = (state_n != state) &&
                   !((state == S_WFETCH && state_n == S_WDX) ||
                     (state == S_WDX && state_n == S_WFETCH));
  assign cnt_inc = xfer_ack && !cnt_clr;

  sdb_count #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  sdb_obuf #(.DW(8)) u_obuf (
    .clk(clk), .rst_n(rst_n), .load(load_ob), .din(xfer_rx),
    .ready(rd_ready), .valid(rd_valid), .dout(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; wr_q <= 1'b0; multi_q <= 1'b0; short_q <= 1'b0;
      stop_pend <= 1'b0; fin_pend <= 1'b0; wbyte <= '0;
      done <= 1'b0; sts_q <= STS_OK; err_tok <= '0;
    end else begin
      state <= state_n;
      done  <= fin;
      if (fin) sts_q <= fin_code;
      if (ev_errtok) err_tok <= xfer_rx;
      if (state == S_IDLE && start) begin
        wr_q <= op_write; multi_q <= op_multi; short_q <= op_short;
        stop_pend <= 1'b0; fin_pend <= 1'b0;
      end else if (stop_req) begin
        stop_pend <= 1'b1;
      end
      if (state_n == S_CMD || state_n == S_STOPTOK) fin_pend <= 1'b1;
      if (state == S_WFETCH && wr_valid) wbyte <= wr_data;
    end
  end

  assign busy   = (state != S_IDLE);
  assign status = sts_q;

  logic unused_wr;
  assign unused_wr = wr_q;
endmodule

// File: rtl/sdb_xfer_chk.sv
module sdb_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic [7:0] err_tok,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       wr_ready,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_ack,
  input logic       ev_token,
  input logic       ev_errtok,
  input logic       ev_resp_ok,
  input logic       ev_resp_bad
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!xfer_req && !wr_ready)); // R1
  AST_TOKEN_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_token |=> (busy && !done)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R3
  AST_ERR_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_errtok |=> (done && status == 2'd1 && err_tok[7:5] == 3'b000)); // R5
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx))); // R8
  AST_RESP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_bad |=> (done && status == 2'd3)); // R9
  AST_RESP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_ok |=> (busy && !done)); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !$past(done))); // R12
endmodule

bind sdb_xfer_engine sdb_xfer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .err_tok(err_tok), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .wr_ready(wr_ready), .xfer_req(xfer_req),
  .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .ev_token(ev_token),
  .ev_errtok(ev_errtok), .ev_resp_ok(ev_resp_ok), .ev_resp_bad(ev_resp_bad)
);

// File: tb/sdb_xfer_engine_tb.sv
`timescale 1ns/1ps
module sdb_xfer_engine_tb_top;
  localparam int TL = 20;
  localparam int BL = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, op_write = 0, op_multi = 0, op_short = 0, stop_req = 0;
  logic busy, done, rd_valid, wr_ready, xfer_req;
  logic [1:0] status;
  logic [7:0] err_tok, rd_data, xfer_tx;
  logic rd_ready = 0, wr_valid = 0, xfer_ack = 0;
  logic [7:0] wr_data = 0, xfer_rx = 8'hFF;

  always #2.5 clk = ~clk;

  sdb_xfer_engine #(.LONG_LEN(512), .SHORT_LEN(16), .TOKEN_LIMIT(TL), .BUSY_LIMIT(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write), .op_multi(op_multi),
    .op_short(op_short), .stop_req(stop_req), .busy(busy), .done(done), .status(status),
    .err_tok(err_tok), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  // behavioural card and stream model
  logic [7:0] exp_tx[$], card_rx[$], exp_rd[$], wr_src[$];
  int checks = 0, errors = 0;
  string tag = "R1";
  logic [1:0] exp_sts;
  logic [7:0] exp_etok, e_b;
  bit done_seen, bp_on, wr_hs, abort;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void px(input logic [7:0] t, input logic [7:0] r);
    exp_tx.push_back(t);
    card_rx.push_back(r);
  endfunction

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 37 + s * 11) ^ (i >> 4));
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (wr_hs && wr_src.size() > 0) void'(wr_src.pop_front());
    wr_valid = (wr_src.size() > 0) && (!bp_on || lfsr[0]);
    wr_data  = (wr_src.size() > 0) ? wr_src[0] : 8'h00;
    rd_ready = !bp_on || lfsr[1] || lfsr[4];
    if (xfer_ack) xfer_ack = 1'b0;
    else if (xfer_req) begin
      if (exp_tx.size() == 0) chk(1'b0, "unexpected exchange", xfer_tx, 0);
      else begin
        e_b = exp_tx.pop_front();
        chk(xfer_tx == e_b, "host byte", xfer_tx, e_b);
      end
      xfer_rx  = (card_rx.size() > 0) ? card_rx.pop_front() : 8'hFF;
      xfer_ack = 1'b1;
    end
    #1;
    wr_hs = wr_valid && wr_ready;
    if (rd_valid && rd_ready) begin
      if (exp_rd.size() == 0) chk(1'b0, "extra read byte", rd_data, 0);
      else begin
        e_b = exp_rd.pop_front();
        chk(rd_data == e_b, "read byte", rd_data, e_b);
      end
    end
    if (done) begin
      done_seen = 1'b1;
      chk(status == exp_sts, "status", status, exp_sts);
      if (exp_sts == 2'd1) chk(err_tok == exp_etok, "error token", err_tok, exp_etok);
      chk(exp_tx.size() == 0, "exchanges left", exp_tx.size(), 0);
    end
  end

  task automatic rd_block(input int n, input int s, input bit noise);
    px(8'hFF, 8'hFF);
    if (noise) begin px(8'hFF, 8'hF0); px(8'hFF, 8'h7F); end
    px(8'hFF, 8'hFE);
    for (int i = 0; i < n; i++) begin
      px(8'hFF, pat(i, s));
      exp_rd.push_back(pat(i, s));
    end
    px(8'hFF, 8'h5A); px(8'hFF, 8'hA5);
  endtask

  task automatic wr_block(input int n, input int s, input bit multi, input logic [7:0] resp, input int busy_n);
    px(multi ? 8'hFC : 8'hFE, 8'hFF);
    for (int i = 0; i < n; i++) begin
      px(pat(i, s), 8'hFF);
      wr_src.push_back(pat(i, s));
    end
    px(8'hFF, 8'hFF); px(8'hFF, 8'hFF);
    px(8'hFF, resp);
    if (resp[4:0] == 5'b00101) begin
      for (int i = 0; i < busy_n; i++) px(8'hFF, 8'h00);
      if (busy_n < BL) px(8'hFF, 8'hFF);
    end
  endtask

  task automatic stop_tail(input logic [7:0] r1);
    px(8'h4C, 8'hFE); px(8'h00, 8'h11); px(8'h00, 8'h22);
    px(8'h00, 8'h33); px(8'h00, 8'h44); px(8'h61, 8'h55);
    px(8'hFF, 8'h3A);
    px(8'hFF, 8'hFF);
    px(8'hFF, r1);
    if (r1 == 8'h00) begin px(8'hFF, 8'h00); px(8'hFF, 8'hFF); end
  endtask

  task automatic run(input string t, input bit w, input bit m, input bit sh,
                     input int stop_at, input bit poke, input logic [1:0] sts);
    int cyc;
    bit stopped;
    if (abort) return;
    tag = t; exp_sts = sts; done_seen = 0; stopped = 0; cyc = 0;
    @(negedge clk);
    start = 1; op_write = w; op_multi = m; op_short = sh;
    @(negedge clk);
    start = 0;
    #2 chk(busy == 1'b1, "busy after start", busy, 1);
    while (!done_seen) begin
      @(negedge clk);
      stop_req = 0; start = 0; op_write = w;
      cyc++;
      if (stop_at >= 0 && !stopped && ((w ? wr_src.size() : exp_rd.size()) <= stop_at)) begin
        stop_req = 1; stopped = 1;
      end
      if (poke && cyc == 40) begin start = 1; op_write = !w; end
      if (cyc > 30000) begin
        chk(1'b0, "watchdog expired", 0, 1);
        abort = 1;
        break;
      end
    end
    repeat (3) @(negedge clk);
    chk(exp_rd.size() == 0, "read bytes missing", exp_rd.size(), 0);
    chk(wr_src.size() == 0, "write bytes unused", wr_src.size(), 0);
    chk(busy == 1'b0, "idle after done", busy, 0);
    exp_tx.delete(); card_rx.delete(); exp_rd.delete(); wr_src.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    tag = "R1";
    chk(xfer_req == 0, "req after reset", xfer_req, 0);
    chk(rd_valid == 0, "rd_valid after reset", rd_valid, 0);
    chk(wr_ready == 0, "wr_ready after reset", wr_ready, 0);
    chk(busy == 0, "busy after reset", busy, 0);
    chk(done == 0, "done after reset", done, 0);

    bp_on = 0; rd_block(16, 1, 1);              run("R2 R4", 0, 0, 1, -1, 0, 2'd0);
    bp_on = 1; rd_block(512, 2, 0);             run("R3", 0, 0, 0, -1, 0, 2'd0);
    bp_on = 0; exp_etok = 8'h09; px(8'hFF, 8'hFF); px(8'hFF, 8'h09);
                                                run("R5", 0, 0, 1, -1, 0, 2'd1);
    for (int i = 0; i < TL; i++) px(8'hFF, 8'hFF);
                                                run("R6", 0, 0, 1, -1, 0, 2'd2);
    bp_on = 1; rd_block(16, 3, 0); rd_block(16, 4, 1); stop_tail(8'h00);
                                                run("R7", 0, 1, 1, 8, 0, 2'd0);
    bp_on = 0; rd_block(16, 5, 0); stop_tail(8'h04);
                                                run("R7 reject", 0, 1, 1, 999, 0, 2'd3);
    px(8'hFF, 8'hFF); wr_block(16, 6, 0, 8'hE5, 3);
                                                run("R8", 1, 0, 1, -1, 0, 2'd0);
    px(8'hFF, 8'hFF); wr_block(16, 7, 0, 8'h0B, 0);
                                                run("R9", 1, 0, 1, -1, 0, 2'd3);
    px(8'hFF, 8'hFF); wr_block(16, 8, 0, 8'hE5, BL);
                                                run("R10", 1, 0, 1, -1, 0, 2'd2);
    bp_on = 1; px(8'hFF, 8'hFF); wr_block(16, 9, 1, 8'hE5, 2); wr_block(16, 10, 1, 8'hE5, 4);
    px(8'hFD, 8'hFF); px(8'hFF, 8'hFF); px(8'hFF, 8'h00); px(8'hFF, 8'h00); px(8'hFF, 8'hFF);
                                                run("R11 R12", 1, 1, 1, 8, 1, 2'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule